// File: doc/BRIEF.md
# Programmable 2/3-Cell Chain Frequency Divider

This block divides a fast input clock by any integer from 128 to 255. The divider is a chain of seven dual-modulus cells. Each cell normally divides the rate of its input ticks by two. It divides by three for one period when its program bit is set and the stage after it signals the end of its own cycle. Tick pulses travel forward along the chain. The end-of-cycle (modulus) signal starts at the last cell and ripples back toward the first cell through one AND gate per stage. The result is a ratio of 128 plus the 7-bit program word. The modulus output of the first cell is the divider output: a one-cycle pulse, once per full division cycle.

The program word arrives over two wires, a load clock and a load data line, which the fast clock oversamples. The bits go into a 7-bit shadow shift register. The active word that drives the cells is copied from the shadow only in the cycle that carries the output pulse. A division cycle that is already running therefore always ends with the ratio it started with.

All cells share the input clock. A tick entering cell i acts as that cell's clock enable, so cell i holds its state until the cell before it completes a period.

Top module: `mmd_divider`

## Requirements
- R1: While rst_n is low, div_pulse is low. After reset the active word is 0, so the divider first runs at a ratio of 128.
- R2: With active word B, consecutive div_pulse assertions are exactly 128 + B clk_in cycles apart.
- R3: The ratio reaches both ends of its range: word 0 gives 128 cycles and word 127 gives 255 cycles.
- R4: div_pulse is high for exactly one clk_in cycle per division cycle.
- R5: A word is loaded as 7 bits, most significant bit first. On each rising edge of ld_clk, the bit on ld_data is shifted in. Both lines are sampled through a two-flop synchronizer, and ld_clk high and low phases last at least two clk_in cycles.
- R6: The shadow word becomes the active word only at a div_pulse. If loading finishes partway through a division cycle, that cycle still completes with the old ratio.
- R7: While ld_clk stays idle, the active word is held, and consecutive intervals have the same length.
- R8: A cell stretches its period to three input ticks only when its program bit is 1 and its downstream modulus signal is active. A single set bit k therefore adds exactly 2^k cycles to the ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Fast clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_clk | input | 1 | Serial load clock; bits shift in on its rising edge |
| ld_data | input | 1 | Serial load data, MSB first |
| div_pulse | output | 1 | One-cycle pulse per division cycle |

## Verification
A wrong counter state in any cell changes the spacing of div_pulse. An error in cell k shifts the interval by a multiple of 2^k, and it appears at the very next pulse, at most 255 cycles later. A word that is shifted wrongly or taken over at the wrong moment appears as an interval that differs from 128 + B in the bits that are wrong. A transfer made partway through a cycle distorts the interval that is already running. Checking intervals measured pulse to pulse against the loaded word therefore catches both kinds of fault within one division cycle.

// File: rtl/mmd_pkg.sv
package mmd_pkg;
  localparam int unsigned DIV_STAGES = 7;
  localparam int unsigned CELL_CW    = 2;
  typedef logic [CELL_CW-1:0] cell_cnt_t;
  localparam cell_cnt_t CNT_HALF = cell_cnt_t'(1);
  localparam cell_cnt_t CNT_EXT  = cell_cnt_t'(2);
endpackage

// File: rtl/mmd_cell.sv
module mmd_cell
  import mmd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick_in,
  input  logic mod_in,
  input  logic prog,
  output logic tick_out,
  output logic mod_out
);
  cell_cnt_t cnt_q, cnt_d;
  logic      stretch;
  logic      at_last;

  always_comb begin
    stretch  = prog & mod_in;
    at_last  = stretch ? (cnt_q == CNT_EXT) : (cnt_q == CNT_HALF);
    tick_out = tick_in & at_last;
    mod_out  = mod_in & at_last;
    cnt_d    = cnt_q;
    if (tick_in) begin
      cnt_d = at_last ? '0 : cnt_q + cell_cnt_t'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_CNT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q != 2'd3); // R8
  AST_STRETCH_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_EXT) |-> (prog && mod_in)); // R8
endmodule

// File: rtl/mmd_serial_loader.sv
module mmd_serial_loader #(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ser_clk,
  input  logic         ser_dat,
  output logic [W-1:0] word
);
  logic [2:0]   sclk_q, sclk_d;
  logic [1:0]   sdat_q, sdat_d;
  logic [W-1:0] sh_q, sh_d;
  logic         shift_en;

  always_comb begin
    sclk_d   = {sclk_q[1:0], ser_clk};
    sdat_d   = {sdat_q[0], ser_dat};
    shift_en = sclk_q[1] & ~sclk_q[2];
    sh_d     = sh_q;
    if (shift_en) sh_d = {sh_q[W-2:0], sdat_q[1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '0;
      sdat_q <= '0;
      sh_q   <= '0;
    end else begin
      sclk_q <= sclk_d;
      sdat_q <= sdat_d;
      sh_q   <= sh_d;
    end
  end

  assign word = sh_q;

  AST_SHIFT_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sh_q) |-> $past(shift_en)); // R5
endmodule

// File: rtl/mmd_divider.sv
module mmd_divider
  import mmd_pkg::*;
#(
  parameter int unsigned STAGES = DIV_STAGES
) (
  input  logic clk_in,
  input  logic rst_n,
  input  logic ld_clk,
  input  logic ld_data,
  output logic div_pulse
);
  localparam int unsigned RATIO_MIN = 1 << STAGES;
  localparam int unsigned RATIO_MAX = (2 << STAGES) - 1;
  localparam int unsigned PER_W     = STAGES + 1;

  logic [1:0]        rst_ff;
  logic              rst_sync;
  logic [STAGES-1:0] shadow;
  logic [STAGES-1:0] word_q, word_d;
  logic              tick [0:STAGES];
  logic              modc [0:STAGES];

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) rst_ff <= '0;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_sync = rst_ff[1];

  mmd_serial_loader #(.W(STAGES)) i_loader (
    .clk     (clk_in),
    .rst_n   (rst_sync),
    .ser_clk (ld_clk),
    .ser_dat (ld_data),
    .word    (shadow)
  );

  assign tick[0]      = 1'b1;
  assign modc[STAGES] = 1'b1;

  for (genvar i = 0; i < STAGES; i++) begin : g_cell
    mmd_cell i_cell (
      .clk      (clk_in),
      .rst_n    (rst_sync),
      .tick_in  (tick[i]),
      .mod_in   (modc[i+1]),
      .prog     (word_q[i]),
      .tick_out (tick[i+1]),
      .mod_out  (modc[i])
    );
  end

  assign div_pulse = modc[0];

  always_comb begin
    word_d = word_q;
    if (div_pulse) word_d = shadow;
  end

  always_ff @(posedge clk_in or negedge rst_sync) begin
    if (!rst_sync) word_q <= '0;
    else           word_q <= word_d;
  end

  logic [PER_W-1:0] per_q;
  always_ff @(posedge clk_in or negedge rst_sync) begin
    if (!rst_sync)     per_q <= '0;
    else if (div_pulse) per_q <= '0;
    else               per_q <= per_q + PER_W'(1);
  end

  AST_PERIOD_RANGE: assert property (@(posedge clk_in) disable iff (!rst_sync)
    div_pulse |-> (int'(per_q) >= int'(RATIO_MIN) - 1 && int'(per_q) <= int'(RATIO_MAX) - 1)); // R2
  AST_CHAIN_AGREE: assert property (@(posedge clk_in) disable iff (!rst_sync)
    tick[STAGES] == div_pulse); // R2
  AST_PULSE_SINGLE: assert property (@(posedge clk_in) disable iff (!rst_sync)
    div_pulse |=> !div_pulse); // R4
  AST_WORD_AT_PULSE: assert property (@(posedge clk_in) disable iff (!rst_sync)
    !$stable(word_q) |-> $past(div_pulse)); // R6
  AST_QUIET_IN_RESET: assert property (@(posedge clk_in)
    !rst_sync |-> !div_pulse); // R1
endmodule

// File: tb/test_mmd_divider.sv
`timescale 1ns/1ps
module test_mmd_divider;
  logic clk_in = 1'b0;
  logic rst_n;
  logic ld_clk;
  logic ld_data;
  logic div_pulse;

  int n_checks = 0;
  int n_fails  = 0;
  int exp_q[$];
  int tag_q[$];
  bit running = 1'b0;
  bit seen    = 1'b0;
  bit prev_p  = 1'b0;
  int gap     = 0;

  always #10 clk_in = ~clk_in;

  mmd_divider i_mmd_divider (
    .clk_in    (clk_in),
    .rst_n     (rst_n),
    .ld_clk    (ld_clk),
    .ld_data   (ld_data),
    .div_pulse (div_pulse)
  );

  task automatic check(input bit ok, input int req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL R%0d actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input int ratio, input int req);
    exp_q.push_back(ratio);
    tag_q.push_back(req);
  endtask

  task automatic wait_pulse();
    do @(negedge clk_in); while (!div_pulse);
    #1;
  endtask

  task automatic wait_drained();
    while (exp_q.size() != 0) @(negedge clk_in);
  endtask

  // R5: MSB first, one bit per rising edge of ld_clk
  task automatic load_word(input logic [6:0] w, input int k);
    for (int b = 6; b >= 0; b--) begin
      @(negedge clk_in);
      ld_data = w[b];
      repeat (k) @(negedge clk_in);
      ld_clk = 1'b1;
      repeat (k) @(negedge clk_in);
      ld_clk = 1'b0;
    end
    repeat (4) @(negedge clk_in);
  endtask

  // scoreboard monitor: interval between pulses against queued ratio
  always @(negedge clk_in) begin
    if (running && rst_n) begin
      if (div_pulse) begin
        check(!prev_p, 4, 1, 0); // R4 single-cycle pulse
        if (seen && exp_q.size() > 0) begin
          int e, t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(gap + 1 == e, t, gap + 1, e);
        end
        seen = 1'b1;
        gap  = 0;
      end else begin
        gap++;
      end
      prev_p = div_pulse;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_in);
    n_fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n   = 1'b0;
    ld_clk  = 1'b0;
    ld_data = 1'b0;
    repeat (5) @(negedge clk_in);
    check(div_pulse == 1'b0, 1, int'(div_pulse), 0); // R1 quiet in reset
    rst_n   = 1'b1;
    running = 1'b1;
    push(128, 1); // R1 reset word gives 128
    push(128, 7); // R7 idle loader keeps ratio
    wait_drained();

    load_word(7'd127, 4);
    wait_pulse();
    push(255, 6); // R6 word 127 running while next load lands
    load_word(7'd0, 2);
    wait_pulse();
    push(128, 3); // R3 lower bound after mid-cycle load
    wait_drained();

    load_word(7'd127, 3);
    wait_pulse();
    push(255, 3); // R3 upper bound
    push(255, 7); // R7 held word repeats
    wait_drained();

    begin
      int words [7] = '{85, 42, 1, 64, 100, 126, 3};
      int tags  [7] = '{5, 5, 8, 8, 2, 2, 2};
      for (int n = 0; n < 7; n++) begin
        load_word(words[n][6:0], 3);
        wait_pulse();
        push(128 + words[n], tags[n]); // R2 R5 R8 ratio 128 + word
        wait_drained();
      end
    end

    repeat (3) @(negedge clk_in);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule